// File: doc/BRIEF.md
# Exception Entry and Return Unit

This block handles the register side of taking an interrupt and returning from one in a simple 32-bit core. It accepts three kinds of entry: a program exception with a type code, a system call, and a timer time-out. It also accepts a return-from-interrupt request and a direct write of the machine state register. On entry it saves a return address and the current machine state, rewrites the machine state, and sends the core to a new fetch address. The upper half of that address comes from a vector prefix register. The lower half is a fixed offset for each kind of entry.

The unit holds the machine state register, two save registers and an exception syndrome register. On a return, the fetch address is loaded from the first save register and the machine state from the second, in the same cycle. Every change is captured on one clock edge. The redirect strobe and the new address appear one cycle after the request is sampled. The core decodes instructions and feeds in the current and next sequential instruction addresses. The timer logic supplies the status flag and its enable.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, msr, srr0, srr1 and esr are zero, redirect_vld is 0, and the vector prefix holds parameter VEC_PREFIX_RST (default 0x0040).
- R2: A program request (prog_req=1) is sampled at a clock edge. The unit then shows all of the following after that edge:
  - redirect_vld is 1.
  - redirect_pc is {prefix, PROG_OFF}, with PROG_OFF defaulting to 0x0700.
  - srr0 is cur_pc.
  - srr1 is the old msr.
  - esr is prog_type zero-extended to 32 bits.
  - msr keeps only bit 17, bit 12 and bit 9 of the old msr, and every other bit is 0.
- R3: A system call (sc_req=1) gives the following after the edge:
  - redirect_pc is {prefix, SC_OFF}, with SC_OFF defaulting to 0x0C00.
  - srr0 is next_pc.
  - srr1 is the old msr.
  - msr is the old msr with bits 25, 19, 18, 15, 14, 10, 5 and 4 cleared, and all other bits kept.
  - esr is unchanged.
- R4: A timer entry is taken only when tmr_status, tmr_enable and msr bit 15 are all 1 at the edge. When taken:
  - redirect_pc is {prefix, TMR_OFF}, with TMR_OFF defaulting to 0x1000.
  - srr0 is next_pc.
  - srr1 is the old msr.
  - msr is cleared with the same bit mask as R3.
  - When the entry is not taken, tmr_status has no effect.
- R5: A return (rfi_req=1) with no entry taken sets redirect_pc to the old srr0 and msr to the old srr1. srr0, srr1 and esr are unchanged.
- R6: When requests arrive together, the priority is program, then system call, then timer. A return or an msr write in a cycle where any entry is taken is ignored.
- R7: redirect_vld is 1 for exactly the cycle after each entry or return, and 0 after any other cycle, including an msr write.
- R8: msr_wr_en=1 with no entry and no return loads msr_wr_data into msr after the edge. The other registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_req | input | 1 | Program exception request |
| prog_type | input | TYPE_W | Program exception type code |
| sc_req | input | 1 | System call request |
| tmr_status | input | 1 | Timer time-out status flag |
| tmr_enable | input | 1 | Timer interrupt enable |
| cur_pc | input | 32 | Address of the current instruction |
| next_pc | input | 32 | Address of the next sequential instruction |
| rfi_req | input | 1 | Return from interrupt request |
| msr_wr_en | input | 1 | Direct machine state write enable |
| msr_wr_data | input | 32 | Direct machine state write value |
| redirect_vld | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 32 | New fetch address |
| msr | output | 32 | Machine state register |
| srr0 | output | 32 | Saved return address |
| srr1 | output | 32 | Saved machine state |
| esr | output | 32 | Exception syndrome register |

## Verification
A wrong save or mask is visible on msr, srr0 or srr1 one cycle after the entry. If it goes unseen there, the next return replays the error onto redirect_pc and msr. A wrong priority or a missing gate on the timer shows at once as the wrong offset in redirect_pc or as a strobe where none was due. The stimulus mixes random requests, many of them arriving together, with directed cases around the timer gate and the all-ones and all-zeros machine state.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN = 32;
  localparam int HALF = XLEN / 2;

  // machine state bit positions
  localparam int B_AP  = 25;
  localparam int B_APE = 19;
  localparam int B_WE  = 18;
  localparam int B_CE  = 17;
  localparam int B_EE  = 15;
  localparam int B_PR  = 14;
  localparam int B_ME  = 12;
  localparam int B_DWE = 10;
  localparam int B_DE  = 9;
  localparam int B_IR  = 5;
  localparam int B_DR  = 4;

  localparam logic [XLEN-1:0] PROG_KEEP =
    (XLEN'(1) << B_CE) | (XLEN'(1) << B_ME) | (XLEN'(1) << B_DE);

  localparam logic [XLEN-1:0] ASYNC_CLR =
    (XLEN'(1) << B_AP) | (XLEN'(1) << B_APE) | (XLEN'(1) << B_WE) |
    (XLEN'(1) << B_EE) | (XLEN'(1) << B_PR)  | (XLEN'(1) << B_DWE) |
    (XLEN'(1) << B_IR) | (XLEN'(1) << B_DR);

  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_PROG  = 3'd1,
    EV_SC    = 3'd2,
    EV_TMR   = 3'd3,
    EV_RFI   = 3'd4,
    EV_MSRWR = 3'd5
  } exc_ev_e;
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic    prog_req,
  input  logic    sc_req,
  input  logic    tmr_take,
  input  logic    rfi_req,
  input  logic    msr_wr_en,
  output exc_ev_e ev
);
  always_comb begin
    if (prog_req)       ev = EV_PROG;
    else if (sc_req)    ev = EV_SC;
    else if (tmr_take)  ev = EV_TMR;
    else if (rfi_req)   ev = EV_RFI;
    else if (msr_wr_en) ev = EV_MSRWR;
    else                ev = EV_NONE;
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_pkg::*;
#(
  parameter logic [HALF-1:0] PROG_OFF = 16'h0700,
  parameter logic [HALF-1:0] SC_OFF   = 16'h0C00,
  parameter logic [HALF-1:0] TMR_OFF  = 16'h1000
) (
  input  exc_ev_e         ev,
  input  logic [HALF-1:0] prefix,
  input  logic [XLEN-1:0] srr0_q,
  input  logic [XLEN-1:0] msr_q,
  input  logic [XLEN-1:0] srr1_q,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] pc_nxt,
  output logic [XLEN-1:0] msr_nxt
);
  always_comb begin
    pc_nxt  = '0;
    msr_nxt = msr_q;
    unique case (ev)
      EV_PROG: begin
        pc_nxt  = {prefix, PROG_OFF};
        msr_nxt = msr_q & PROG_KEEP;
      end
      EV_SC: begin
        pc_nxt  = {prefix, SC_OFF};
        msr_nxt = msr_q & ~ASYNC_CLR;
      end
      EV_TMR: begin
        pc_nxt  = {prefix, TMR_OFF};
        msr_nxt = msr_q & ~ASYNC_CLR;
      end
      EV_RFI: begin
        pc_nxt  = srr0_q;
        msr_nxt = srr1_q;
      end
      EV_MSRWR: msr_nxt = wr_data;
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int              TYPE_W         = 4,
  parameter logic [HALF-1:0] VEC_PREFIX_RST = 16'h0040,
  parameter logic [HALF-1:0] PROG_OFF       = 16'h0700,
  parameter logic [HALF-1:0] SC_OFF         = 16'h0C00,
  parameter logic [HALF-1:0] TMR_OFF        = 16'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic [TYPE_W-1:0] prog_type,
  input  logic              sc_req,
  input  logic              tmr_status,
  input  logic              tmr_enable,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   next_pc,
  input  logic              rfi_req,
  input  logic              msr_wr_en,
  input  logic [XLEN-1:0]   msr_wr_data,
  output logic              redirect_vld,
  output logic [XLEN-1:0]   redirect_pc,
  output logic [XLEN-1:0]   msr,
  output logic [XLEN-1:0]   srr0,
  output logic [XLEN-1:0]   srr1,
  output logic [XLEN-1:0]   esr
);
  logic            rst_int_n;
  exc_ev_e         ev;
  logic            tmr_take;
  logic            state_en;
  logic [HALF-1:0] prefix_q;
  logic [XLEN-1:0] msr_q, srr0_q, srr1_q, esr_q, pc_q;
  logic [XLEN-1:0] msr_d, srr0_d, srr1_d, esr_d, pc_d;
  logic            vld_q, vld_d;

  exc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_int_n)
  );

  assign tmr_take = tmr_status & tmr_enable & msr_q[B_EE];

  exc_arbiter u_arb (
    .prog_req(prog_req), .sc_req(sc_req), .tmr_take(tmr_take),
    .rfi_req(rfi_req), .msr_wr_en(msr_wr_en), .ev(ev)
  );

  exc_vector_gen #(
    .PROG_OFF(PROG_OFF), .SC_OFF(SC_OFF), .TMR_OFF(TMR_OFF)
  ) u_vec (
    .ev(ev), .prefix(prefix_q), .srr0_q(srr0_q), .msr_q(msr_q),
    .srr1_q(srr1_q), .wr_data(msr_wr_data), .pc_nxt(pc_d), .msr_nxt(msr_d)
  );

  // next-state for save registers and strobe
  always_comb begin
    srr0_d   = srr0_q;
    srr1_d   = srr1_q;
    esr_d    = esr_q;
    vld_d    = 1'b0;
    state_en = (ev != EV_NONE);
    unique case (ev)
      EV_PROG: begin
        srr0_d = cur_pc;
        srr1_d = msr_q;
        esr_d  = {{(XLEN-TYPE_W){1'b0}}, prog_type};
        vld_d  = 1'b1;
      end
      EV_SC, EV_TMR: begin
        srr0_d = next_pc;
        srr1_d = msr_q;
        vld_d  = 1'b1;
      end
      EV_RFI: vld_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      prefix_q <= VEC_PREFIX_RST;
      msr_q    <= '0;
      srr0_q   <= '0;
      srr1_q   <= '0;
      esr_q    <= '0;
      pc_q     <= '0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (state_en) begin
        msr_q  <= msr_d;
        srr0_q <= srr0_d;
        srr1_q <= srr1_d;
        esr_q  <= esr_d;
      end
      if (vld_d) pc_q <= pc_d;
    end
  end

  assign redirect_vld = vld_q;
  assign redirect_pc  = pc_q;
  assign msr          = msr_q;
  assign srr0         = srr0_q;
  assign srr1         = srr1_q;
  assign esr          = esr_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int              TYPE_W   = 4,
  parameter logic [HALF-1:0] PROG_OFF = 16'h0700,
  parameter logic [HALF-1:0] SC_OFF   = 16'h0C00,
  parameter logic [HALF-1:0] TMR_OFF  = 16'h1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_req,
  input logic [TYPE_W-1:0] prog_type,
  input logic              sc_req,
  input logic              tmr_status,
  input logic              tmr_enable,
  input logic [XLEN-1:0]   cur_pc,
  input logic [XLEN-1:0]   next_pc,
  input logic              rfi_req,
  input logic              msr_wr_en,
  input logic [XLEN-1:0]   msr_wr_data,
  input logic              redirect_vld,
  input logic [XLEN-1:0]   redirect_pc,
  input logic [XLEN-1:0]   msr,
  input logic [XLEN-1:0]   srr0,
  input logic [XLEN-1:0]   srr1,
  input logic [XLEN-1:0]   esr
);
  logic tmr_ok, any_int;
  assign tmr_ok  = tmr_status && tmr_enable && msr[B_EE];
  assign any_int = prog_req || sc_req || tmr_ok;

  // R2
  prog_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> redirect_vld && redirect_pc[HALF-1:0] == PROG_OFF &&
                 srr0 == $past(cur_pc) && srr1 == $past(msr) &&
                 esr == XLEN'($past(prog_type)));

  // R3
  sc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !prog_req) |=> redirect_pc[HALF-1:0] == SC_OFF &&
                              srr0 == $past(next_pc) && $stable(esr));

  // R4
  tmr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ok && !prog_req && !sc_req) |=> redirect_pc[HALF-1:0] == TMR_OFF &&
                                         !msr[B_EE] && srr1 == $past(msr));

  // R5
  rfi_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfi_req && !any_int) |=> redirect_vld && redirect_pc == $past(srr0) &&
                              msr == $past(srr1) && $stable(srr0));

  // R7
  no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_int && !rfi_req) |=> !redirect_vld);

  // R8
  msr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_wr_en && !any_int && !rfi_req) |=> msr == $past(msr_wr_data));
endmodule

bind exc_entry_unit exc_entry_chk #(
  .TYPE_W(TYPE_W), .PROG_OFF(PROG_OFF), .SC_OFF(SC_OFF), .TMR_OFF(TMR_OFF)
) chk_i (
  .clk(clk), .rst_n(rst_int_n), .prog_req(prog_req), .prog_type(prog_type),
  .sc_req(sc_req), .tmr_status(tmr_status), .tmr_enable(tmr_enable),
  .cur_pc(cur_pc), .next_pc(next_pc), .rfi_req(rfi_req),
  .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data),
  .redirect_vld(redirect_vld), .redirect_pc(redirect_pc), .msr(msr),
  .srr0(srr0), .srr1(srr1), .esr(esr)
);

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_req, sc_req, tmr_status, tmr_enable, rfi_req, msr_wr_en;
  logic [TW-1:0] prog_type;
  logic [31:0] cur_pc, next_pc, msr_wr_data;
  logic        redirect_vld;
  logic [31:0] redirect_pc, msr, srr0, srr1, esr;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic [31:0] e_msr, e_srr0, e_srr1, e_esr, e_pc;
  logic        e_vld;
  localparam logic [31:0] KEEP_P = 32'h0002_1200; // bits 17,12,9
  localparam logic [31:0] CLR_A  = 32'h020C_C430; // bits 25,19,18,15,14,10,5,4
  localparam logic [15:0] PFX    = 16'h0040;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_unit #(.TYPE_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_type(prog_type),
    .sc_req(sc_req), .tmr_status(tmr_status), .tmr_enable(tmr_enable),
    .cur_pc(cur_pc), .next_pc(next_pc), .rfi_req(rfi_req),
    .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data),
    .redirect_vld(redirect_vld), .redirect_pc(redirect_pc), .msr(msr),
    .srr0(srr0), .srr1(srr1), .esr(esr)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model, compare at next negedge
  task automatic step(logic p, logic [TW-1:0] pt, logic s, logic ts, logic te,
                      logic r, logic w, logic [31:0] wd);
    logic [31:0] cp, np;
    string tag;
    int nreq;
    cp = $urandom;
    np = cp + 32'd4;
    prog_req = p; prog_type = pt; sc_req = s; tmr_status = ts; tmr_enable = te;
    rfi_req = r; msr_wr_en = w; msr_wr_data = wd; cur_pc = cp; next_pc = np;
    nreq = int'(p) + int'(s) + int'(ts && te && e_msr[15]) + int'(r) + int'(w);
    e_vld = 1'b0;
    if (p) begin
      tag = "R2"; e_vld = 1; e_pc = {PFX, 16'h0700};
      e_srr0 = cp; e_srr1 = e_msr; e_esr = 32'(pt); e_msr = e_msr & KEEP_P;
    end else if (s) begin
      tag = "R3"; e_vld = 1; e_pc = {PFX, 16'h0C00};
      e_srr0 = np; e_srr1 = e_msr; e_msr = e_msr & ~CLR_A;
    end else if (ts && te && e_msr[15]) begin
      tag = "R4"; e_vld = 1; e_pc = {PFX, 16'h1000};
      e_srr0 = np; e_srr1 = e_msr; e_msr = e_msr & ~CLR_A;
    end else if (r) begin
      tag = "R5"; e_vld = 1; e_pc = e_srr0; e_msr = e_srr1;
    end else if (w) begin
      tag = "R8"; e_msr = wd;
    end else begin
      tag = ts ? "R4" : "R7";
    end
    if (nreq > 1) tag = "R6";
    @(posedge clk);
    @(negedge clk);
    chk("R7", "redirect_vld", 32'(redirect_vld), 32'(e_vld));
    if (e_vld) chk(tag, "redirect_pc", redirect_pc, e_pc);
    chk(tag, "msr", msr, e_msr);
    chk(tag, "srr0", srr0, e_srr0);
    chk(tag, "srr1", srr1, e_srr1);
    chk(tag, "esr", esr, e_esr);
  endtask

  task automatic idle();
    step(0, '0, 0, 0, 0, 0, 0, '0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    prog_req = 0; prog_type = '0; sc_req = 0; tmr_status = 0; tmr_enable = 0;
    rfi_req = 0; msr_wr_en = 0; msr_wr_data = '0; cur_pc = '0; next_pc = '0;
    e_msr = '0; e_srr0 = '0; e_srr1 = '0; e_esr = '0; e_pc = '0; e_vld = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "msr", msr, '0);
    chk("R1", "srr0", srr0, '0);
    chk("R1", "srr1", srr1, '0);
    chk("R1", "esr", esr, '0);
    chk("R1", "redirect_vld", 32'(redirect_vld), '0);

    // R1 prefix seen through a system call vector
    step(0, '0, 1, 0, 0, 0, 0, '0);
    idle();
    // R8 write all ones, then program entry keeps only three bits (R2)
    step(0, '0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
    step(1, 4'hA, 0, 0, 0, 0, 0, '0);
    chk("R2", "msr keep mask", msr, 32'h0002_1200);
    // R5 return restores all ones
    step(0, '0, 0, 0, 0, 1, 0, '0);
    chk("R5", "msr restored", msr, 32'hFFFF_FFFF);
    // R3 system call from all ones
    step(0, '0, 1, 0, 0, 0, 0, '0);
    chk("R3", "msr clear mask", msr, 32'hFDF3_3BCF);
    // R4 timer blocked while EE is 0
    step(0, '0, 0, 0, 0, 0, 1, 32'h0000_0000);
    step(0, '0, 0, 1, 1, 0, 0, '0);
    step(0, '0, 0, 1, 0, 0, 1, 32'h0000_8000);
    step(0, '0, 0, 1, 0, 0, 0, '0);
    // R4 timer taken with EE set
    step(0, '0, 0, 1, 1, 0, 0, '0);
    // R6 all requests together, then sc with timer and rfi
    step(0, '0, 0, 0, 0, 0, 1, 32'h0000_8000);
    step(1, 4'h3, 1, 1, 1, 1, 1, 32'h1234_5678);
    step(0, '0, 0, 0, 0, 0, 1, 32'h0000_8000);
    step(0, '0, 1, 1, 1, 1, 1, 32'h1234_5678);
    step(0, '0, 0, 0, 0, 0, 1, 32'h0000_8000);
    step(0, '0, 0, 1, 1, 1, 0, '0);
    idle();

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic p, s, ts, te, r, w;
      p  = ($urandom % 10) == 0;
      s  = ($urandom % 10) == 0;
      ts = ($urandom % 3) == 0;
      te = ($urandom % 2) == 0;
      r  = ($urandom % 6) == 0;
      w  = ($urandom % 4) == 0;
      step(p, TW'($urandom), s, ts, te, r, w, $urandom);
    end

    summary();
    $finish;
  end
endmodule